// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Flags

This block holds a small bank of lock flags shared by the two sides of a dual-port memory system. Each side reaches the flags through its own select strobe, separate from the memory array, together with a short flag address, a write enable and a single data bit. The flags never touch memory contents. Software on either side uses them to agree on who may use a region of the shared memory.

A side asks for a flag by writing a zero to it. It then reads the flag in a later cycle. A zero read back means that side now holds the flag. A one means the other side holds it. The losing side is never stalled. Its request stays latched, and when the holder releases the flag by writing a one, ownership moves to the waiting side in the same update. A side that no longer wants a flag it is waiting for can withdraw by writing a one.

Reads complete without delay and show the current flag state. Bit 0 carries the state, and that value is repeated on every other data bit.

Top module: `semflag_pair`

## Requirements
- R1: After reset every flag is free with no request latched, and a read of any flag from either side returns all ones.
- R2: A side that writes a zero (strobe high, write high, data 0) to a free flag reads that flag as all zeros from the next cycle on.
- R3: A side that requests a flag held by the other side reads all ones, with no stall, and the holder keeps reading zeros.
- R4: A holder that writes a one to its flag reads all ones from the next cycle. If the other side has a request latched, that side reads all zeros from the next cycle.
- R5: When both sides write a zero to the same free flag in the same cycle, the left side wins and the right side's request stays latched.
- R6: Each flag is independent. Operations on one address never change what is read at another address.
- R7: A side that writes a one to a flag it does not hold cancels its own latched request. A later release by the holder then leaves the flag free on both sides.
- R8: Read data is 0 or all ones: all ones means the reading side does not hold the flag, and all zeros means it does. The read data is all zeros when the strobe is low or when the side is writing.
- R9: Request, grant, release and handover behave the same with the right side as holder and the left side waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel | input | 1 | Left side semaphore strobe |
| l_wr | input | 1 | Left side write enable (1 = write, 0 = read) |
| l_addr | input | ADDR_W (3) | Left side flag address |
| l_wdata | input | 1 | Left side write bit (0 = request, 1 = release/cancel) |
| l_rdata | output | DATA_W (16) | Left side read data |
| r_sel | input | 1 | Right side semaphore strobe |
| r_wr | input | 1 | Right side write enable |
| r_addr | input | ADDR_W (3) | Right side flag address |
| r_wdata | input | 1 | Right side write bit |
| r_rdata | output | DATA_W (16) | Right side read data |

## Verification
Two states are hard to reach from the ports. The first is a same-cycle collision on a free flag. The second is a handover in which the waiting request was latched many cycles before the release. The bench reaches the collision by driving both sides' strobes on the same falling edge, so that one rising edge captures both zero writes. It reaches the handover by parking a request from the losing side, reading both sides in between, and only then releasing. A cancel followed by a release shows that the withdrawn request is truly gone and does not cause a stale handover.

// File: rtl/semflag_pkg.sv
// Shared types for the two-port semaphore flag bank.
// Assumes two sides only, named left and right.
package semflag_pkg;

    // Holder of one flag
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    // Per-flag command from one side for one cycle
    typedef struct packed {
        logic ask;   // write of zero: request
        logic drop;  // write of one: release or cancel
    } flag_cmd_t;

endpackage

// File: rtl/semflag_dec.sv
// Decodes one side's strobe, write enable, address and data bit into a
// per-flag command vector. At most one flag gets a command per cycle, and
// ask and drop are never both set.
module semflag_dec
    import semflag_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic                  sel,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wdata,
    output flag_cmd_t             cmd [NUM_FLAGS]
);

    logic do_write;

    // A write happens only when the strobe and write enable are both high
    always_comb do_write = sel && wr;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cmd
        // Route the write to the addressed flag only
        always_comb begin
            cmd[g].ask  = do_write && (addr == ADDR_W'(g)) && !wdata;
            cmd[g].drop = do_write && (addr == ADDR_W'(g)) &&  wdata;
        end
    end

endmodule

// File: rtl/semflag_cell.sv
// One semaphore flag. It keeps a request latch for each side and the
// current holder. When the flag is free, a left request takes priority. On
// a release, a request still latched by the other side takes over in the
// same update. A drop from the non-holder cancels its request.
// Assumes the commands come from semflag_dec (ask and drop exclusive).
module semflag_cell
    import semflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  flag_cmd_t  cmd_l,
    input  flag_cmd_t  cmd_r,
    output logic       held_l,
    output logic       held_r
);

    logic    want_l, want_r;
    logic    want_l_nx, want_r_nx;
    holder_e holder, holder_nx;

    // Next request latches: ask sets, drop clears
    always_comb begin
        want_l_nx = cmd_l.ask ? 1'b1 : (cmd_l.drop ? 1'b0 : want_l);
        want_r_nx = cmd_r.ask ? 1'b1 : (cmd_r.drop ? 1'b0 : want_r);
    end

    // Next holder: keep, hand over on release, or grant with left priority
    always_comb begin
        holder_nx = holder;
        unique case (holder)
            HOLD_LEFT: begin
                if (!want_l_nx) holder_nx = want_r_nx ? HOLD_RIGHT : HOLD_NONE;
            end
            HOLD_RIGHT: begin
                if (!want_r_nx) holder_nx = want_l_nx ? HOLD_LEFT : HOLD_NONE;
            end
            default: begin
                if (want_l_nx)      holder_nx = HOLD_LEFT;
                else if (want_r_nx) holder_nx = HOLD_RIGHT;
                else                holder_nx = HOLD_NONE;
            end
        endcase
    end

    // State register with synchronous reset to free and idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_l <= 1'b0;
            want_r <= 1'b0;
            holder <= HOLD_NONE;
        end else begin
            want_l <= want_l_nx;
            want_r <= want_r_nx;
            holder <= holder_nx;
        end
    end

    // Holder indications towards the read path
    always_comb begin
        held_l = (holder == HOLD_LEFT);
        held_r = (holder == HOLD_RIGHT);
    end

    // Free flag asked by left becomes left-held
    p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (holder == HOLD_NONE && cmd_l.ask) |=> (holder == HOLD_LEFT));

    // Holder keeps the flag while it does not drop it
    p_keep_holder_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (holder == HOLD_LEFT && !cmd_l.drop) |=> (holder == HOLD_LEFT));

    // Release with a latched right request hands the flag over
    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (holder == HOLD_LEFT && cmd_l.drop && want_r && !cmd_r.drop)
        |=> (holder == HOLD_RIGHT));

    // Release with a latched left request hands the flag over (mirror)
    p_handover_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (holder == HOLD_RIGHT && cmd_r.drop && want_l && !cmd_l.drop)
        |=> (holder == HOLD_LEFT));

    // Same-cycle asks on a free flag: left wins, right stays latched
    p_tie_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (holder == HOLD_NONE && cmd_l.ask && cmd_r.ask)
        |=> (holder == HOLD_LEFT && want_r));

    // A right drop without an ask leaves no right request latched
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_r.drop && !cmd_r.ask) |=> !want_r);

endmodule

// File: rtl/semflag_rdmux.sv
// Read path for one side. It picks the addressed flag's holder indication
// and spreads it across the data width: all zeros when this side holds the
// flag, all ones otherwise. Outside a read cycle the output is all zeros.
module semflag_rdmux #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS),
    parameter int DATA_W    = 16
) (
    input  logic [NUM_FLAGS-1:0] held,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    output logic [DATA_W-1:0]    rdata
);

    logic flag_bit;

    // Flag state as seen by this side: 0 = held here
    always_comb flag_bit = !held[addr];

    // Replicate on all bits during reads, otherwise drive zeros
    always_comb rdata = (sel && !wr) ? {DATA_W{flag_bit}} : '0;

    // Read data is always uniform across its bits
    always_comb begin
        if (sel && !wr) begin
            p_uniform_r8: assert (rdata == '0 || rdata == '1);
        end
    end

endmodule

// File: rtl/semflag_pair.sv
// Bank of semaphore flags shared by a left and a right side. Each side has
// its own strobe, address, write enable and data bit. Writes update the
// flags at the clock edge, and reads show the state at once with no wait.
// Assumes NUM_FLAGS is a power of two so that every address selects a flag.
module semflag_pair
    import semflag_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS),
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    flag_cmd_t              cmd_l [NUM_FLAGS];
    flag_cmd_t              cmd_r [NUM_FLAGS];
    logic [NUM_FLAGS-1:0]   held_l, held_r;

    semflag_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .addr(l_addr), .wdata(l_wdata), .cmd(cmd_l)
    );

    semflag_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .addr(r_addr), .wdata(r_wdata), .cmd(cmd_r)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        semflag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_l  (cmd_l[g]),
            .cmd_r  (cmd_r[g]),
            .held_l (held_l[g]),
            .held_r (held_r[g])
        );
    end

    semflag_rdmux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_l (
        .held(held_l), .sel(l_sel), .wr(l_wr), .addr(l_addr), .rdata(l_rdata)
    );

    semflag_rdmux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_r (
        .held(held_r), .sel(r_sel), .wr(r_wr), .addr(r_addr), .rdata(r_rdata)
    );

    // Right side never reads zero (holds) a flag the left side holds
    p_no_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_wr && r_sel && !r_wr && l_addr == r_addr && l_rdata == '0)
        |-> (r_rdata == '1));

    // Writes never drive read data
    p_quiet_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_wr) |-> (l_rdata == '0));

endmodule

// File: tb/semflag_pair_test.sv
module semflag_pair_test;

    localparam int NF = 8;
    localparam int AW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sel = 1'b0, l_wr = 1'b0, l_wdata = 1'b0;
    logic          r_sel = 1'b0, r_wr = 1'b0, r_wdata = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_rdata, r_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    semflag_pair #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one bit from a side (0 = left, 1 = right), lasting one edge
    task automatic wr_side(input bit side, input int a, input bit v);
        @(negedge clk);
        if (!side) begin l_sel = 1; l_wr = 1; l_addr = AW'(a); l_wdata = v; end
        else       begin r_sel = 1; r_wr = 1; r_addr = AW'(a); r_wdata = v; end
        @(negedge clk);
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    endtask

    // Both sides write in the same cycle
    task automatic wr_both(input int al, input bit vl, input int ar, input bit vr);
        @(negedge clk);
        l_sel = 1; l_wr = 1; l_addr = AW'(al); l_wdata = vl;
        r_sel = 1; r_wr = 1; r_addr = AW'(ar); r_wdata = vr;
        @(negedge clk);
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    endtask

    // Read a flag from one side and compare against the expected bit
    task automatic rd_side(input bit side, input int a, input bit exp, input string req);
        @(negedge clk);
        if (!side) begin l_sel = 1; l_wr = 0; l_addr = AW'(a); end
        else       begin r_sel = 1; r_wr = 0; r_addr = AW'(a); end
        #1;
        check(req, side ? r_rdata : l_rdata, {DW{exp}});
        l_sel = 0; r_sel = 0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < NF; i++) begin
            rd_side(0, i, 1'b1, "R1");
            rd_side(1, i, 1'b1, "R1");
        end
        #1;
        check("R8 idle", l_rdata, '0);
        check("R8 idle", r_rdata, '0);
    endtask

    task automatic t_grant_release;
        wr_side(0, 2, 1'b0);
        rd_side(0, 2, 1'b0, "R2");
        rd_side(1, 2, 1'b1, "R3");
        wr_side(1, 2, 1'b0);
        rd_side(1, 2, 1'b1, "R3 pending");
        rd_side(0, 2, 1'b0, "R3 holder");
        wr_side(0, 2, 1'b1);
        rd_side(0, 2, 1'b1, "R4 released");
        rd_side(1, 2, 1'b0, "R4 handover");
        wr_side(1, 2, 1'b1);
        rd_side(1, 2, 1'b1, "R4 free");
        rd_side(0, 2, 1'b1, "R4 free");
    endtask

    task automatic t_tie;
        wr_both(5, 1'b0, 5, 1'b0);
        rd_side(0, 5, 1'b0, "R5 left wins");
        rd_side(1, 5, 1'b1, "R5 right loses");
        wr_side(0, 5, 1'b1);
        rd_side(1, 5, 1'b0, "R5 right latched");
        wr_side(1, 5, 1'b1);
        rd_side(0, 5, 1'b1, "R5 free");
    endtask

    task automatic t_indep;
        wr_both(0, 1'b0, 7, 1'b0);
        rd_side(0, 0, 1'b0, "R6");
        rd_side(1, 7, 1'b0, "R6");
        for (int i = 1; i < NF - 1; i++) begin
            rd_side(0, i, 1'b1, "R6 other");
            rd_side(1, i, 1'b1, "R6 other");
        end
        rd_side(1, 0, 1'b1, "R6");
        rd_side(0, 7, 1'b1, "R6");
        wr_both(0, 1'b1, 7, 1'b1);
        rd_side(0, 0, 1'b1, "R6 free");
        rd_side(1, 7, 1'b1, "R6 free");
    endtask

    task automatic t_cancel;
        wr_side(0, 3, 1'b0);
        wr_side(1, 3, 1'b0);
        wr_side(1, 3, 1'b1);
        rd_side(0, 3, 1'b0, "R7 holder kept");
        wr_side(0, 3, 1'b1);
        rd_side(1, 3, 1'b1, "R7 no stale handover");
        rd_side(0, 3, 1'b1, "R7 free");
        wr_side(1, 3, 1'b0);
        rd_side(1, 3, 1'b0, "R7 free grant");
        wr_side(1, 3, 1'b1);
    endtask

    task automatic t_mirror;
        wr_side(1, 4, 1'b0);
        rd_side(1, 4, 1'b0, "R9 right grant");
        wr_side(0, 4, 1'b0);
        rd_side(0, 4, 1'b1, "R9 left waits");
        rd_side(0, 4, 1'b1, "R9 left waits");
        wr_side(1, 4, 1'b1);
        rd_side(0, 4, 1'b0, "R9 handover");
        rd_side(1, 4, 1'b1, "R9 right released");
        wr_side(0, 4, 1'b1);
        rd_side(0, 4, 1'b1, "R9 free");
    endtask

    task automatic t_format;
        wr_side(0, 6, 1'b0);
        @(negedge clk);
        l_sel = 1; l_wr = 1; l_addr = 3'd6; l_wdata = 1'b0;
        r_sel = 1; r_wr = 0; r_addr = 3'd6;
        #1;
        check("R8 write quiet", l_rdata, '0);
        check("R8 replicate", r_rdata, '1);
        l_sel = 0; l_wr = 0; r_sel = 0;
        rd_side(0, 6, 1'b0, "R8 replicate");
        wr_side(0, 6, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_grant_release();
        t_tie();
        t_indep();
        t_cancel();
        t_mirror();
        t_format();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule